// File: doc/BRIEF.md
# Double-Precision Ordering, Min/Max and Saturate Unit

This block takes two IEEE-754 binary64 operands and an operation code. It returns a 64-bit result together with three ordering flags: less-than, greater-or-equal and equal. The ordering is found with a single signed 64-bit integer compare of the raw bit patterns. An XOR with a "both operands negative" term corrects that compare. An equality term, which treats the two zeros as the same value, masks it.

From that ordering the unit picks the minimum or the maximum of the pair. It can also clamp operand A into [0, 1], flip the sign of A, or clear the sign of A. It performs no arithmetic and no rounding, and it leaves NaN payloads untouched. Inputs are captured on a cycle where the valid input is high. Results and flags appear registered one cycle later and hold until the next valid input.

Top module: `fp64_order_unit`

## Requirements
- R1: During and straight after reset, `out_valid`, `result`, `flag_lt`, `flag_ge` and `flag_eq` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. On cycles with `in_valid` low, `result` and the three flags keep their previous values whatever the other inputs do.
- R3: An operand is NaN when bits 62:52 are all ones and bits 51:0 are not all zero. `flag_lt` is high exactly when neither operand is NaN and A is numerically below B. Positive and negative zero are not below each other.
- R4: `flag_ge` is high exactly when neither operand is NaN and A is not numerically below B, so at most one of `flag_lt` and `flag_ge` is set.
- R5: `flag_eq` is high exactly when neither operand is NaN and either the bit patterns match or both operands are zeros of any sign.
- R6: `op_sel` encoding: 3'b000 less-than, 3'b001 greater-or-equal, 3'b010 equal, 3'b011 minimum, 3'b100 maximum, 3'b101 saturate, 3'b110 negate, 3'b111 absolute. For the three compare codes, `result` is the selected flag zero-extended to 64 bits. The flags are updated on every valid input whatever the code.
- R7: Minimum returns A when A is not NaN and either B is NaN or A is below B. Otherwise it returns B, so with equal operands, and with ±0 in particular, the answer is B.
- R8: Maximum returns B under the same condition that makes minimum return A. Otherwise it returns A.
- R9: Saturate acts on A. It returns 64'h0 when A is NaN or bit 63 of A is set. It returns 64'h3FF0000000000000 when A is above 1.0, +infinity included. Otherwise it returns A unchanged.
- R10: Negate returns A with bit 63 inverted, and absolute returns A with bit 63 cleared. Both apply to NaN inputs as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture the inputs on this cycle |
| op_sel | input | 3 | Operation code (see R6) |
| opa | input | 64 | Operand A, binary64 |
| opb | input | 64 | Operand B, binary64 |
| out_valid | output | 1 | Result and flags were updated on the previous edge |
| result | output | 64 | Selected result |
| flag_lt | output | 1 | A below B, both ordered |
| flag_ge | output | 1 | A not below B, both ordered |
| flag_eq | output | 1 | A equal to B, both ordered |

## Verification
The hardest cases are those where the raw signed compare gives the wrong answer: two negative operands, a +0/−0 pair, and NaN patterns whose sign bit makes them look like very negative integers. A random stream would almost never produce these together. The stimulus therefore sweeps every ordered pair drawn from a fixed set of sixteen edge values under all eight operation codes. The set covers both zeros, both infinities, positive and negative NaNs, the smallest subnormals and the neighbours of 1.0. Expected values come from native real-number comparison of the decoded operands.

// File: rtl/fp64_order_unit.sv
module fp64_order_unit #(
  parameter int W = 64,
  parameter int EXP_W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         flag_lt,
  output logic         flag_ge,
  output logic         flag_eq
);
  localparam int FRAC_W = W - 1 - EXP_W;
  localparam logic [W-1:0] SIGN_BIT = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ONE_VAL = {2'b00, {(EXP_W-1){1'b1}}, {FRAC_W{1'b0}}};

  logic a_nan, b_nan, ordered;
  logic raw_lt, both_neg, same_val, lt_core;
  logic lt_w, ge_w, eq_w, pick_a;
  logic [W-1:0] sat_w;
  logic [W-1:0] res_w;

  assign a_nan = (&opa[W-2 -: EXP_W]) && (|opa[FRAC_W-1:0]);
  assign b_nan = (&opb[W-2 -: EXP_W]) && (|opb[FRAC_W-1:0]);
  assign ordered = !a_nan && !b_nan;

  assign raw_lt   = $signed(opa) < $signed(opb);
  assign both_neg = opa[W-1] & opb[W-1];
  assign same_val = (opa == opb) || ((opa[W-2:0] | opb[W-2:0]) == '0);
  assign lt_core  = !same_val && (raw_lt != both_neg);

  assign lt_w = ordered && lt_core;
  assign ge_w = ordered && !lt_core;
  assign eq_w = ordered && same_val;
  assign pick_a = (b_nan || lt_core) && !a_nan;

  always_comb begin
    if (a_nan || opa[W-1]) sat_w = '0;
    else if ($signed(opa) > $signed(ONE_VAL)) sat_w = ONE_VAL;
    else sat_w = opa;
  end

  always_comb begin
    unique case (op_sel)
      3'd0: res_w = {{(W-1){1'b0}}, lt_w};
      3'd1: res_w = {{(W-1){1'b0}}, ge_w};
      3'd2: res_w = {{(W-1){1'b0}}, eq_w};
      3'd3: res_w = pick_a ? opa : opb;
      3'd4: res_w = pick_a ? opb : opa;
      3'd5: res_w = sat_w;
      3'd6: res_w = opa ^ SIGN_BIT;
      default: res_w = opa & ~SIGN_BIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_lt   <= 1'b0;
      flag_ge   <= 1'b0;
      flag_eq   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_w;
        flag_lt <= lt_w;
        flag_ge <= ge_w;
        flag_eq <= eq_w;
      end
    end
  end
endmodule

module fp64_order_unit_chk #(
  parameter int W = 64,
  parameter int EXP_W = 11
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [2:0]   op_sel,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         flag_lt,
  input logic         flag_ge,
  input logic         flag_eq
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R2
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(flag_lt));  // R2
  AST_LT_GE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_lt && flag_ge));  // R4
  AST_EQ_IMPLIES_GE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_eq |-> flag_ge);  // R5
  AST_NEG_FLIPS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd6) |=>
      (result[W-1] != $past(opa[W-1])) && (result[W-2:0] == $past(opa[W-2:0])));  // R10
  AST_ABS_CLEARS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd7) |=> !result[W-1]);  // R10
endmodule

bind fp64_order_unit fp64_order_unit_chk #(.W(W), .EXP_W(EXP_W)) u_chk (.*);

// File: tb/fp64_order_unit_tb.sv
module fp64_order_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        out_valid;
  logic [63:0] result;
  logic        flag_lt, flag_ge, flag_eq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] vals [16];

  always #4 clk = ~clk;

  fp64_order_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
    .flag_lt(flag_lt), .flag_ge(flag_ge), .flag_eq(flag_eq)
  );

  function automatic bit isnan(logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, op_sel, opa, opb, act, exp_v);
    end
  endtask

  task automatic run_vec(logic [2:0] op, logic [63:0] a, logic [63:0] b);
    real ra, rb;
    bit na, nb, e_lt, e_ge, e_eq, sel_a;
    logic [63:0] e_res;
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; opa = a; opb = b;
    ra = $bitstoreal(a); rb = $bitstoreal(b);
    na = isnan(a); nb = isnan(b);
    e_lt = !na && !nb && (ra < rb);
    e_ge = !na && !nb && !(ra < rb);
    e_eq = !na && !nb && (ra == rb);
    sel_a = !na && (nb || (ra < rb));
    case (op)
      3'd0: e_res = {63'd0, e_lt};
      3'd1: e_res = {63'd0, e_ge};
      3'd2: e_res = {63'd0, e_eq};
      3'd3: e_res = sel_a ? a : b;
      3'd4: e_res = sel_a ? b : a;
      3'd5: e_res = (na || a[63]) ? 64'd0 : (ra > 1.0) ? 64'h3FF0000000000000 : a;
      3'd6: e_res = {~a[63], a[62:0]};
      default: e_res = {1'b0, a[62:0]};
    endcase
    @(negedge clk);
    chk("R2 out_valid", {63'd0, out_valid}, 64'd1);
    chk("R3 flag_lt", {63'd0, flag_lt}, {63'd0, e_lt});
    chk("R4 flag_ge", {63'd0, flag_ge}, {63'd0, e_ge});
    chk("R5 flag_eq", {63'd0, flag_eq}, {63'd0, e_eq});
    case (op)
      3'd3: chk("R7 min", result, e_res);
      3'd4: chk("R8 max", result, e_res);
      3'd5: chk("R9 sat", result, e_res);
      3'd6, 3'd7: chk("R10 neg/abs", result, e_res);
      default: chk("R6 compare result", result, e_res);
    endcase
  endtask

  task automatic idle_check();
    logic [63:0] keep_r;
    logic [2:0] keep_f;
    keep_r = result;
    keep_f = {flag_lt, flag_ge, flag_eq};
    @(negedge clk);
    in_valid = 1'b0; op_sel = 3'd6; opa = ~opa; opb = ~opb;
    @(negedge clk);
    @(negedge clk);
    chk("R2 idle out_valid", {63'd0, out_valid}, 64'd0);
    chk("R2 idle hold result", result, keep_r);
    chk("R2 idle hold flags", {61'd0, flag_lt, flag_ge, flag_eq}, {61'd0, keep_f});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vals[0]  = 64'h0000000000000000; vals[1]  = 64'h8000000000000000;
    vals[2]  = 64'h3FF0000000000000; vals[3]  = 64'hBFF0000000000000;
    vals[4]  = 64'h3FF0000000000001; vals[5]  = 64'h3FEFFFFFFFFFFFFF;
    vals[6]  = 64'h7FF0000000000000; vals[7]  = 64'hFFF0000000000000;
    vals[8]  = 64'h7FF8000000000000; vals[9]  = 64'hFFF0000000000001;
    vals[10] = 64'h0000000000000001; vals[11] = 64'h8000000000000001;
    vals[12] = 64'h7FEFFFFFFFFFFFFF; vals[13] = 64'hC000000000000000;
    vals[14] = 64'h4000000000000000; vals[15] = 64'h3FE0000000000000;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", {63'd0, out_valid}, 64'd0);
    chk("R1 reset result", result, 64'd0);
    chk("R1 reset flags", {61'd0, flag_lt, flag_ge, flag_eq}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {62'd0, out_valid, flag_lt}, 64'd0);
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++)
          run_vec(op[2:0], vals[i], vals[j]);
        idle_check();
      end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule